// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the programmed contents of a device's base registers into address windows and then uses them to claim accesses. There are six base registers and one expansion-ROM register. Each region's size and space type (I/O or memory) are fixed by parameters. An update pulse latches a new set of windows, computed from the command word and the register values. For each region the latched set gives a valid flag, a base and a limit.

The windows are computed once and stored. Decoding an access is then a set of range compares against the stored windows. The access address and its space type are compared with every valid window, and the block returns a one-hot hit, an encoded index, a hit flag and an overlap flag. Programmings that cannot be decoded safely are reported as unmapped rather than decoded. These are a zero base, a window that wraps, an I/O window that reaches past 64K, a memory window that ends at the top address, and a ROM with its enable bit clear.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is asserted and after it is released, with no update yet, every region reports valid 0, base 0 and limit 0, and no access hits.
- R2: Valid, base and limit are loaded from the current inputs at a clock edge where `upd` is 1, and are visible after that edge. While `upd` is 0 they hold, whatever the inputs do.
- R3: An I/O region can be valid only if bit 0 of `cmd_word` was 1 at the update. A memory region or the ROM can be valid only if bit 1 was 1. Bits 15:2 of `cmd_word` have no effect.
- R4: Region i reads its register at `bar_flat[i*AW +: AW]`, and the ROM occupies the last slot (index NUM_BAR). The base is the register value ANDed with NOT(size-1), and the limit is base + size - 1.
- R5: A region whose computed base is zero, or whose limit is not above its base (a wrap or a size of 1), is unmapped. An unmapped region reports valid 0, base 0 and limit 0.
- R6: An I/O region whose limit is 0x10000 or higher is unmapped.
- R7: A memory region (including the ROM) whose limit is all ones is unmapped.
- R8: The ROM region is valid only if bit 0 of its register was 1 at the update.
- R9: A region whose size parameter is 0 is never valid and never hit.
- R10: Region i hits when it is valid, `acc_io` equals its type (1 = I/O), and base <= `acc_addr` <= limit. The hit outputs follow the address without a clock delay.
- R11: When several regions hit, `hit_onehot` holds only the lowest index and `hit_idx` encodes it. `hit_any` is 1 for any hit, and `overlap` is 1 when two or more regions hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd | input | 1 | Recompute and latch windows at this edge |
| cmd_word | input | 16 | Command word; bit 0 enables I/O, bit 1 enables memory |
| bar_flat | input | NUM_WIN*AW | Six base registers then the ROM register |
| acc_addr | input | AW | Access address |
| acc_io | input | 1 | Access space: 1 = I/O, 0 = memory |
| win_valid | output | NUM_WIN | Region mapped |
| win_base | output | NUM_WIN*AW | Region base, 0 when unmapped |
| win_limit | output | NUM_WIN*AW | Region limit, 0 when unmapped |
| hit_onehot | output | NUM_WIN | Lowest-index hit, one-hot |
| hit_any | output | 1 | Some region hit |
| hit_idx | output | IDX_W | Index of the winning region |
| overlap | output | 1 | Two or more regions hit |

## Verification
The gating assertions assume that `cmd_word` and the ROM register are stable across the update edge, so that the values sampled with `upd` are the ones that were latched. The stimulus changes inputs only on the falling edge and holds them through the pulse. The checks on window shape assume that the size parameters are powers of two, which elaboration enforces. The random register values are biased toward zero, toward the top of the address space, toward small I/O addresses and toward one shared memory base, so every unmapped rule and the overlap case are reached.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   localparam int unsigned CMD_IO_BIT   = 0;
   localparam int unsigned CMD_MEM_BIT  = 1;
   localparam int unsigned CMD_W        = 16;
   localparam int unsigned IO_SPACE_TOP = 32'h0001_0000;
   localparam int unsigned MIN_AW       = 17;
endpackage

// File: rtl/bwd_window_calc.sv
module bwd_window_calc #(
   parameter int unsigned   AW     = 32,
   parameter logic [AW-1:0] SIZE   = '0,
   parameter bit            IS_IO  = 1'b0,
   parameter bit            IS_ROM = 1'b0
) (
   input  logic [AW-1:0] raw,
   input  logic          io_en,
   input  logic          mem_en,
   output logic          ok,
   output logic [AW-1:0] base,
   output logic [AW-1:0] limit
);
   generate
      if (SIZE == '0) begin : g_absent
         logic unused_in;
         assign unused_in = ^{raw, io_en, mem_en};
         assign ok    = 1'b0;
         assign base  = '0;
         assign limit = '0;
      end else begin : g_present
         localparam logic [AW-1:0] MASK   = ~(SIZE - 1'b1);
         localparam logic [AW-1:0] IO_TOP = AW'(bwd_pkg::IO_SPACE_TOP);
         logic [AW:0]   sum;
         logic [AW-1:0] b;
         logic          space_en;
         logic          top_ok;
         logic          shape_ok;

         assign b        = raw & MASK;
         assign sum      = {1'b0, b} + {1'b0, SIZE} - {{AW{1'b0}}, 1'b1};
         assign shape_ok = !sum[AW] && (sum[AW-1:0] > b) && (b != '0);

         if (IS_IO) begin : g_io
            logic unused_mem;
            assign unused_mem = mem_en;
            assign space_en   = io_en;
            assign top_ok     = sum[AW-1:0] < IO_TOP;
         end else begin : g_mem
            logic unused_io;
            assign unused_io = io_en;
            assign top_ok    = ~&sum[AW-1:0];
            if (IS_ROM) begin : g_rom
               assign space_en = mem_en && raw[0];
            end else begin : g_plain
               assign space_en = mem_en;
            end
         end

         assign ok    = space_en && shape_ok && top_ok;
         assign base  = ok ? b : '0;
         assign limit = ok ? sum[AW-1:0] : '0;
      end
   endgenerate
endmodule

// File: rtl/bwd_win_regs.sv
module bwd_win_regs #(
   parameter int unsigned NUM_WIN = 7,
   parameter int unsigned AW      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd,
   input  logic [NUM_WIN-1:0]    d_valid,
   input  logic [NUM_WIN*AW-1:0] d_base,
   input  logic [NUM_WIN*AW-1:0] d_limit,
   output logic [NUM_WIN-1:0]    q_valid,
   output logic [NUM_WIN*AW-1:0] q_base,
   output logic [NUM_WIN*AW-1:0] q_limit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= '0;
         q_base  <= '0;
         q_limit <= '0;
      end else if (upd) begin
         q_valid <= d_valid;
         q_base  <= d_base;
         q_limit <= d_limit;
      end
   end
endmodule

// File: rtl/bwd_match.sv
module bwd_match #(
   parameter int unsigned        NUM_WIN = 7,
   parameter int unsigned        AW      = 32,
   parameter logic [NUM_WIN-1:0] IO_VEC  = '0
) (
   input  logic [NUM_WIN-1:0]    win_valid,
   input  logic [NUM_WIN*AW-1:0] win_base,
   input  logic [NUM_WIN*AW-1:0] win_limit,
   input  logic [AW-1:0]         addr,
   input  logic                  acc_io,
   output logic [NUM_WIN-1:0]    hit_vec
);
   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
         logic lo_ok, hi_ok;
         assign lo_ok      = addr >= win_base[i*AW +: AW];
         assign hi_ok      = addr <= win_limit[i*AW +: AW];
         assign hit_vec[i] = win_valid[i] && (acc_io == IO_VEC[i]) && lo_ok && hi_ok;
      end
   endgenerate
endmodule

// File: rtl/bwd_prio.sv
module bwd_prio #(
   parameter int unsigned NUM_WIN = 7,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   output logic [NUM_WIN-1:0] onehot,
   output logic [IDX_W-1:0]   idx,
   output logic               any,
   output logic               multi
);
   localparam int unsigned CNT_W = $clog2(NUM_WIN + 1);
   logic [CNT_W-1:0] cnt;

   always_comb begin
      onehot = '0;
      idx    = '0;
      cnt    = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IDX_W'(i);
            cnt       = cnt + 1'b1;
         end
      end
   end

   assign any   = |hit_vec;
   assign multi = cnt > CNT_W'(1);
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
   parameter int unsigned              AW       = 32,
   parameter int unsigned              NUM_BAR  = 6,
   parameter logic [NUM_BAR-1:0]       IO_MASK  = 6'b010001,
   parameter logic [(NUM_BAR+1)*AW-1:0] WIN_SIZE = {32'h0001_0000, 32'h0000_0010, 32'h0000_0008,
                                                   32'h0000_0000, 32'h0010_0000, 32'h0000_1000,
                                                   32'h0000_0020},
   localparam int unsigned             NUM_WIN  = NUM_BAR + 1,
   localparam int unsigned             IDX_W    = $clog2(NUM_WIN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd,
   input  logic [15:0]           cmd_word,
   input  logic [NUM_WIN*AW-1:0] bar_flat,
   input  logic [AW-1:0]         acc_addr,
   input  logic                  acc_io,
   output logic [NUM_WIN-1:0]    win_valid,
   output logic [NUM_WIN*AW-1:0] win_base,
   output logic [NUM_WIN*AW-1:0] win_limit,
   output logic [NUM_WIN-1:0]    hit_onehot,
   output logic                  hit_any,
   output logic [IDX_W-1:0]      hit_idx,
   output logic                  overlap
);
   import bwd_pkg::*;

   localparam logic [NUM_WIN-1:0] IO_VEC = {1'b0, IO_MASK};
   localparam logic [AW-1:0]      IO_MAX = AW'(IO_SPACE_TOP);

   generate
      if (AW < MIN_AW) begin : g_bad_aw
         $error("bar_window_decoder: AW too small for the I/O space");
      end
      if (NUM_BAR < 1) begin : g_bad_nbar
         $error("bar_window_decoder: NUM_BAR must be at least 1");
      end
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_size_chk
         localparam logic [AW-1:0] SZ = WIN_SIZE[i*AW +: AW];
         if ((SZ & (SZ - 1'b1)) != '0) begin : g_not_pow2
            $error("bar_window_decoder: region size is not a power of two");
         end
         if (IO_VEC[i] && SZ > IO_MAX) begin : g_io_big
            $error("bar_window_decoder: I/O region larger than the I/O space");
         end
         if (i == NUM_BAR && SZ == AW'(1)) begin : g_rom_tiny
            $error("bar_window_decoder: ROM size 1 leaves no room for its enable bit");
         end
      end
   endgenerate

   logic                  io_en, mem_en;
   logic                  unused_cmd;
   logic [NUM_WIN-1:0]    nxt_valid;
   logic [NUM_WIN*AW-1:0] nxt_base, nxt_limit;
   logic [NUM_WIN-1:0]    hit_vec;

   assign io_en      = cmd_word[CMD_IO_BIT];
   assign mem_en     = cmd_word[CMD_MEM_BIT];
   assign unused_cmd = ^cmd_word[15:2];

   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
         bwd_window_calc #(
            .AW     (AW),
            .SIZE   (WIN_SIZE[i*AW +: AW]),
            .IS_IO  (IO_VEC[i]),
            .IS_ROM (i == NUM_BAR)
         ) calc_i (
            .raw    (bar_flat[i*AW +: AW]),
            .io_en  (io_en),
            .mem_en (mem_en),
            .ok     (nxt_valid[i]),
            .base   (nxt_base[i*AW +: AW]),
            .limit  (nxt_limit[i*AW +: AW])
         );
      end
   endgenerate

   bwd_win_regs #(.NUM_WIN(NUM_WIN), .AW(AW)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd),
      .d_valid (nxt_valid),
      .d_base  (nxt_base),
      .d_limit (nxt_limit),
      .q_valid (win_valid),
      .q_base  (win_base),
      .q_limit (win_limit)
   );

   bwd_match #(.NUM_WIN(NUM_WIN), .AW(AW), .IO_VEC(IO_VEC)) match_i (
      .win_valid (win_valid),
      .win_base  (win_base),
      .win_limit (win_limit),
      .addr      (acc_addr),
      .acc_io    (acc_io),
      .hit_vec   (hit_vec)
   );

   bwd_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) prio_i (
      .hit_vec (hit_vec),
      .onehot  (hit_onehot),
      .idx     (hit_idx),
      .any     (hit_any),
      .multi   (overlap)
   );
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
   parameter int unsigned        AW      = 32,
   parameter int unsigned        NUM_BAR = 6,
   parameter logic [NUM_BAR-1:0] IO_MASK = '0,
   parameter int unsigned        NUM_WIN = NUM_BAR + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  upd,
   input logic [15:0]           cmd_word,
   input logic [NUM_WIN*AW-1:0] bar_flat,
   input logic [NUM_WIN-1:0]    win_valid,
   input logic [NUM_WIN*AW-1:0] win_base,
   input logic [NUM_WIN*AW-1:0] win_limit,
   input logic [NUM_WIN-1:0]    hit_onehot,
   input logic                  hit_any,
   input logic                  overlap
);
   localparam logic [NUM_WIN-1:0] IO_VEC = {1'b0, IO_MASK};
   localparam logic [AW-1:0]      IO_MAX = AW'(bwd_pkg::IO_SPACE_TOP);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(win_valid) && $stable(win_base) && $stable(win_limit)));

   assert_io_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !cmd_word[bwd_pkg::CMD_IO_BIT]) |=> ((win_valid & IO_VEC) == '0));

   assert_mem_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !cmd_word[bwd_pkg::CMD_MEM_BIT]) |=> ((win_valid & ~IO_VEC) == '0));

   assert_rom_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !bar_flat[NUM_BAR*AW]) |=> !win_valid[NUM_BAR]);

   assert_hit_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_onehot & ~win_valid) == '0);

   assert_hit_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_onehot));

   assert_overlap_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      overlap |-> (hit_any && hit_onehot != '0));

   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win_chk
         assert_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid[i] |-> (win_base[i*AW +: AW] != '0 &&
                              win_limit[i*AW +: AW] > win_base[i*AW +: AW]));
         if (IO_VEC[i]) begin : g_io
            assert_io_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
               win_valid[i] |-> (win_limit[i*AW +: AW] < IO_MAX));
         end else begin : g_mem
            assert_mem_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
               win_valid[i] |-> !(&win_limit[i*AW +: AW]));
         end
      end
   endgenerate
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
   .AW      (AW),
   .NUM_BAR (NUM_BAR),
   .IO_MASK (IO_MASK),
   .NUM_WIN (NUM_WIN)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd        (upd),
   .cmd_word   (cmd_word),
   .bar_flat   (bar_flat),
   .win_valid  (win_valid),
   .win_base   (win_base),
   .win_limit  (win_limit),
   .hit_onehot (hit_onehot),
   .hit_any    (hit_any),
   .overlap    (overlap)
);

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;
   localparam int unsigned AW  = 32;
   localparam int unsigned NB  = 6;
   localparam int unsigned NW  = NB + 1;
   localparam logic [NB-1:0] IOM = 6'b010001;
   localparam logic [NW*AW-1:0] SZV = {32'h0001_0000, 32'h0000_0010, 32'h0000_0008,
                                      32'h0000_0000, 32'h0010_0000, 32'h0000_1000,
                                      32'h0000_0020};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [31:0] bar_r [NW];
   logic [NW*AW-1:0] bar_flat;
   logic [AW-1:0] acc_addr = '0;
   logic acc_io = 1'b0;
   logic [NW-1:0] win_valid, hit_onehot;
   logic [NW*AW-1:0] win_base, win_limit;
   logic hit_any, overlap;
   logic [2:0] hit_idx;

   int checks = 0;
   int errors = 0;

   logic        ev [NW];
   logic [31:0] eb [NW];
   logic [31:0] el [NW];

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NW; i++) bar_flat[i*AW +: AW] = bar_r[i];
   end

   bar_window_decoder #(.AW(AW), .NUM_BAR(NB), .IO_MASK(IOM), .WIN_SIZE(SZV)) dut_i (
      .clk(clk), .rst_n(rst_n), .upd(upd), .cmd_word(cmd_word), .bar_flat(bar_flat),
      .acc_addr(acc_addr), .acc_io(acc_io), .win_valid(win_valid), .win_base(win_base),
      .win_limit(win_limit), .hit_onehot(hit_onehot), .hit_any(hit_any),
      .hit_idx(hit_idx), .overlap(overlap)
   );

   function automatic logic is_io(int i);
      return (i < NB) ? IOM[i] : 1'b0;
   endfunction

   // reference for one window from the requirements R3-R9
   function automatic logic [64:0] ref_win(int i, logic [31:0] raw, logic [15:0] cmd);
      logic [31:0] sz, b;
      logic [32:0] l;
      logic en, bad;
      sz = SZV[i*AW +: AW];
      if (sz == 0) return '0;
      en = is_io(i) ? cmd[0] : cmd[1];
      if (i == NB && !raw[0]) en = 1'b0;
      b = raw & ~(sz - 1);
      l = {1'b0, b} + {1'b0, sz} - 33'd1;
      bad = l[32] || (l[31:0] <= b) || (b == 0) ||
            (is_io(i) ? (l[31:0] >= 32'h1_0000) : (l[31:0] == 32'hFFFF_FFFF));
      if (!en || bad) return '0;
      return {1'b1, b, l[31:0]};
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_windows(string req);
      for (int i = 0; i < NW; i++) begin
         check(req, {63'd0, win_valid[i], win_base[i*AW +: AW], win_limit[i*AW +: AW]},
               {63'd0, ev[i], eb[i], el[i]}, $sformatf("window %0d", i));
      end
   endtask

   task automatic do_update();
      @(negedge clk);
      upd = 1'b1;
      for (int i = 0; i < NW; i++) {ev[i], eb[i], el[i]} = ref_win(i, bar_r[i], cmd_word);
      @(negedge clk);
      upd = 1'b0;
      #1;
   endtask

   task automatic check_hit(string req, logic [31:0] a, logic io);
      logic [NW-1:0] oh;
      logic [2:0] idx;
      int n;
      @(negedge clk);
      acc_addr = a;
      acc_io = io;
      #1;
      oh = '0; idx = '0; n = 0;
      for (int i = NW - 1; i >= 0; i--) begin
         if (ev[i] && is_io(i) == io && a >= eb[i] && a <= el[i]) begin
            oh = '0; oh[i] = 1'b1; idx = 3'(i); n++;
         end
      end
      check(req, {117'd0, hit_onehot, hit_any, hit_idx, overlap},
            {117'd0, oh, (n > 0), idx, (n > 1)}, $sformatf("hit addr %h io %0d", a, io));
   endtask

   function automatic logic [31:0] rnd_reg();
      case ($urandom_range(0, 5))
         0: return $urandom;
         1: return $urandom_range(0, 32'h1_FFFF);
         2: return 32'h0;
         3: return 32'hFFFF_FFFF - $urandom_range(0, 32'h1F_FFFF);
         4: return 32'h0010_0001;
         default: return {10'd0, 2'($urandom_range(1, 3)), 20'h0} | 32'($urandom_range(0, 1));
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < NW; i++) begin
         bar_r[i] = '0; ev[i] = 1'b0; eb[i] = '0; el[i] = '0;
      end
      // R1: reset state
      upd = 1'b1;
      cmd_word = 16'hFFFF;
      bar_r[1] = 32'h8000_0000;
      repeat (3) @(negedge clk);
      check("R1", {121'd0, win_valid}, 128'd0, "valid in reset");
      upd = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_windows("R1");
      check_hit("R1", 32'h8000_0010, 1'b0);

      // R3 R4: a clean programming
      cmd_word = 16'h0003;
      bar_r[0] = 32'h0000_1001;
      bar_r[1] = 32'h8000_0000;
      bar_r[2] = 32'h0020_0000;
      bar_r[3] = 32'h4000_0000;
      bar_r[4] = 32'h0000_FFF9;
      bar_r[5] = 32'hFFFF_FFF0;
      bar_r[6] = 32'h000C_0000;
      do_update();
      check_windows("R4");
      check("R4", {64'd0, win_base[31:0], win_limit[31:0]},
            {64'd0, 32'h0000_1000, 32'h0000_101F}, "I/O window 0 literal");
      check("R6", {127'd0, win_valid[4]}, 128'd1, "I/O window ending at 0xFFFF");
      check("R7", {127'd0, win_valid[5]}, 128'd0, "memory window ending at all ones");
      check("R8", {127'd0, win_valid[6]}, 128'd0, "ROM with enable clear");
      check("R9", {127'd0, win_valid[3]}, 128'd0, "size-0 region");
      check_hit("R9", 32'h4000_0000, 1'b0);
      check_hit("R10", 32'h0000_101F, 1'b1);
      check_hit("R10", 32'h0000_1020, 1'b1);
      check_hit("R10", 32'h0000_1000, 1'b0);
      check_hit("R10", 32'h8000_0FFF, 1'b0);

      // R8: ROM enabled
      bar_r[6] = 32'h000C_0001;
      do_update();
      check("R8", {63'd0, win_valid[6], win_base[6*32 +: 32], win_limit[6*32 +: 32]},
            {63'd0, 1'b1, 32'h000C_0000, 32'h000C_FFFF}, "ROM window");

      // R2: hold without update
      bar_r[1] = 32'h9000_0000;
      cmd_word = 16'h0000;
      repeat (3) @(negedge clk);
      #1;
      check_windows("R2");

      // R3: high command bits ignored, enables cleared
      cmd_word = 16'hFFFC;
      do_update();
      check("R3", {121'd0, win_valid}, 128'd0, "all enables clear");
      cmd_word = 16'hAAA9;
      do_update();
      check_windows("R3");
      check("R3", {126'd0, win_valid[4], win_valid[1]}, {126'd0, 1'b1, 1'b0}, "I/O only");

      // R5 R6: degenerate
      cmd_word = 16'h0003;
      bar_r[0] = 32'h0000_0001;
      bar_r[4] = 32'h0001_0001;
      bar_r[2] = 32'hFFF0_0000;
      do_update();
      check_windows("R5");
      check("R5", {126'd0, win_valid[2], win_valid[0]}, 128'd0, "zero base and top window");
      check("R6", {127'd0, win_valid[4]}, 128'd0, "I/O past 64K");

      // R11: overlap, lowest index wins
      bar_r[1] = 32'h0010_0000;
      bar_r[2] = 32'h0010_0000;
      bar_r[5] = 32'h0010_0800;
      do_update();
      check_windows("R11");
      check_hit("R11", 32'h0010_0800, 1'b0);
      check_hit("R11", 32'h0010_0F00, 1'b0);
      check_hit("R11", 32'h0010_1000, 1'b0);

      // random mix
      for (int r = 0; r < 300; r++) begin
         for (int i = 0; i < NW; i++) bar_r[i] = rnd_reg();
         cmd_word = 16'($urandom);
         if ($urandom_range(0, 3) != 0) cmd_word[1:0] = 2'b11;
         if ($urandom_range(0, 3) == 0) begin
            repeat (2) @(negedge clk);
            #1;
            check_windows("R2");
         end else begin
            do_update();
            check_windows("R4");
         end
         for (int k = 0; k < 8; k++) begin
            int j;
            logic [31:0] a;
            j = $urandom_range(0, NW - 1);
            a = $urandom;
            if (ev[j]) begin
               case ($urandom_range(0, 4))
                  0: a = eb[j];
                  1: a = el[j];
                  2: a = eb[j] - 1;
                  3: a = el[j] + 1;
                  default: a = eb[j] + ($urandom % (el[j] - eb[j] + 1));
               endcase
            end
            check_hit("R10", a, ($urandom_range(0, 5) == 0) ? !is_io(j) : is_io(j));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule